// File: doc/BRIEF.md
# Segmented Address Generation Unit

This unit turns 16-bit program offsets into 32-bit bus addresses for a processor whose memory is divided into 65536 segments of 64 KB each. Address bits [31:16] name the segment and bits [15:0] the offset within it. Each access carries a class: instruction fetch, data, zero page, system stack, user stack or interrupt vector. The class selects which segment register, or which page inside a segment, completes the address. The zero page and the system stack page can each be placed on any page of any segment.

The unit also holds the 32-bit program counter and a 32-bit link register. A legacy 16-bit jump keeps its offset and takes the code segment register's upper half as its segment. A far jump loads the whole 32-bit target. An interrupt entry runs the handler in the segment named by the interrupt segment register, while the vector itself is read from segment zero. Calls and interrupt entries save the full 32-bit return address in the link register. Six 32-bit segment registers are loaded through a single-cycle write port. Instruction decode supplies the class, offsets and program-counter commands, so the unit does no decoding of its own.

Top module: `seg_agu`

## Requirements
- R1: After a synchronous active-low reset, the program counter, the link register and all six segment registers are zero, so a data access with offset h1234 and index 0 yields address h0000_1234.
- R2: A write with `wr_en` high loads `wr_data` into the register named by `wr_sel` on the next clock edge: 0 code segment, 1 data segment, 2 zero page base, 3 user stack segment, 4 system stack word (segment [31:16], page [15:8], stack pointer [7:0]), 5 interrupt segment. Selects 6 and 7, and any cycle with `wr_en` low, change no register.
- R3: Class 0 (fetch) gives {pc[31:16], offset+index}, class 1 (data) gives {data_seg[31:16], offset+index}, and class 4 (user stack) gives {ustack_seg[31:16], offset+index}. The 16-bit sum wraps modulo 64 KB and never changes the segment field.
- R4: Class 2 (zero page) gives {zp_base[31:8], (offset[7:0]+index[7:0]) mod 256}. Offset bits [15:8] have no effect, and the sum wraps within the page.
- R5: Class 3 (system stack) gives {sys0[31:8], (sys0[7:0]+offset[7:0]) mod 256}. The index has no effect.
- R6: Class 5 (vector) gives {16'h0000, offset}, with the index ignored. Classes 6 and 7 give address h0000_0000.
- R7: `pc_op` 1 (relative) adds tgt[15:0] to pc[15:0] modulo 64 KB and keeps pc[31:16]. `pc_op` 0 and 7 leave the program counter unchanged.
- R8: `pc_op` 2 (legacy jump) and 3 (legacy call) load {cs[31:16], tgt[15:0]}, using the code segment value from before any write in the same cycle.
- R9: `pc_op` 4 (far jump) and 5 (far call) load the program counter with all 32 bits of `tgt`.
- R10: `pc_op` 6 (interrupt entry) loads {isr_seg[31:16], tgt[15:0]}, where `tgt[15:0]` is the vector fetched from segment zero.
- R11: `pc_op` 3, 5 and 6 load the link register with the program counter value from before the update. All other operations leave the link register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Segment register write enable |
| wr_sel | input | 3 | Segment register select |
| wr_data | input | 32 | Segment register write data |
| acc_class | input | 3 | Access class of the current address |
| offset | input | 16 | Offset within the segment, or page operand |
| index | input | 16 | Index added to the offset |
| pc_op | input | 3 | Program counter operation |
| tgt | input | 32 | Jump target, relative step or vector |
| bus_addr | output | 32 | Physical bus address (combinational) |
| pc | output | 32 | Program counter |
| link | output | 32 | Link register |

## Verification
The bench targets offset sums that cross hFFFF, zero-page and stack sums that cross a page end, and a call issued in the same cycle as a code-segment write. A design that lets the carry reach the segment field would move the access into the next segment. A design that wraps the page operand at 16 bits would leave its page. A design that forwards the new code segment would land the call in the wrong segment. It also checks that the link register keeps its value through relative and far jumps, that writes to unused selects leave every register alone, and that interrupt entry takes its segment from the interrupt register while vector reads stay in segment zero.

// File: rtl/seg_agu_pkg.sv
// Package: shared encodings for the segmented address generation unit.
// Assumes 3-bit class, operation and register-select codes at the top ports.
package seg_agu_pkg;

    // Access class of a bus address request.
    typedef enum logic [2:0] {
        ACC_FETCH = 3'd0,
        ACC_DATA  = 3'd1,
        ACC_ZPG   = 3'd2,
        ACC_SSTK  = 3'd3,
        ACC_USTK  = 3'd4,
        ACC_VEC   = 3'd5,
        ACC_RSV6  = 3'd6,
        ACC_RSV7  = 3'd7
    } acc_e;

    // Program counter operations.
    typedef enum logic [2:0] {
        PC_HOLD = 3'd0,
        PC_REL  = 3'd1,
        PC_LJMP = 3'd2,
        PC_LJSR = 3'd3,
        PC_FAR  = 3'd4,
        PC_FARL = 3'd5,
        PC_IRQ  = 3'd6,
        PC_NOP7 = 3'd7
    } pcop_e;

    // Segment register slots reachable through the write port.
    localparam int SEG_CS    = 0;
    localparam int SEG_DS    = 1;
    localparam int SEG_ZP    = 2;
    localparam int SEG_US    = 3;
    localparam int SEG_SYS0  = 4;
    localparam int SEG_SYS1  = 5;
    localparam int NUM_SEG_REGS = 6;
    localparam int SEL_W        = 3;

endpackage

// File: rtl/seg_agu_regs.sv
// Segment register file: N_REGS words of DATA_W bits with one write port.
// Assumes selects at or above N_REGS are legal and are simply ignored.
module seg_agu_regs #(
    parameter int DATA_W = 32,
    parameter int N_REGS = 6,
    parameter int SEL_W  = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [SEL_W-1:0]               wr_sel,
    input  logic [DATA_W-1:0]              wr_data,
    output logic [N_REGS-1:0][DATA_W-1:0]  regs_q
);

    for (genvar i = 0; i < N_REGS; i++) begin : g_reg
        // Load slot i when it is selected, clear it on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[i] <= '0;
            end else if (wr_en && (wr_sel == SEL_W'(i))) begin
                regs_q[i] <= wr_data;
            end
        end

        p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (wr_sel == SEL_W'(i))) |=> (regs_q[i] == $past(wr_data)));

        p_unselected_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && (wr_sel == SEL_W'(i))) |=> $stable(regs_q[i]));
    end

endmodule

// File: rtl/seg_agu_addr.sv
// Address former: combines the offset, index and the class-selected
// segment/page base into a bus address. Purely combinational; clk and
// rst_n serve the checks only. Assumes PAGE_W < OFF_W < ADDR_W.
module seg_agu_addr
    import seg_agu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int PAGE_W = 8,
    localparam int SEG_W = ADDR_W - OFF_W,
    localparam int ZPB_W = ADDR_W - PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_e              acc_class,
    input  logic [OFF_W-1:0]  offset,
    input  logic [OFF_W-1:0]  index,
    input  logic [SEG_W-1:0]  pc_seg,
    input  logic [SEG_W-1:0]  ds_seg,
    input  logic [SEG_W-1:0]  us_seg,
    input  logic [ZPB_W-1:0]  zp_base,
    input  logic [ADDR_W-1:0] sys0,
    output logic [ADDR_W-1:0] bus_addr
);

    logic [OFF_W-1:0]  lin_off;
    logic [PAGE_W-1:0] zp_low;
    logic [PAGE_W-1:0] sp_low;

    // Offset sums, each wrapping inside its own field width.
    always_comb begin
        lin_off = offset + index;
        zp_low  = offset[PAGE_W-1:0] + index[PAGE_W-1:0];
        sp_low  = sys0[PAGE_W-1:0] + offset[PAGE_W-1:0];
    end

    // Pick the segment or page base by access class.
    always_comb begin
        unique case (acc_class)
            ACC_FETCH: bus_addr = {pc_seg, lin_off};
            ACC_DATA:  bus_addr = {ds_seg, lin_off};
            ACC_USTK:  bus_addr = {us_seg, lin_off};
            ACC_ZPG:   bus_addr = {zp_base, zp_low};
            ACC_SSTK:  bus_addr = {sys0[ADDR_W-1:PAGE_W], sp_low};
            ACC_VEC:   bus_addr = {{SEG_W{1'b0}}, offset};
            default:   bus_addr = '0;
        endcase
    end

    p_data_seg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_class == ACC_DATA) |-> (bus_addr[ADDR_W-1:OFF_W] == ds_seg));

    p_fetch_seg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_class == ACC_FETCH) |-> (bus_addr[ADDR_W-1:OFF_W] == pc_seg));

    p_zpg_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_class == ACC_ZPG) |-> (bus_addr[ADDR_W-1:PAGE_W] == zp_base));

    p_sstk_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_class == ACC_SSTK) |-> (bus_addr[ADDR_W-1:PAGE_W] == sys0[ADDR_W-1:PAGE_W]));

    p_vec_seg_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_class == ACC_VEC) |-> (bus_addr[ADDR_W-1:OFF_W] == '0));

endmodule

// File: rtl/seg_agu_pc.sv
// Program counter and link register. Applies relative, legacy, far and
// interrupt-entry updates; calls save the pre-update counter as link.
// Assumes the code and interrupt segments arrive as their upper halves.
module seg_agu_pc
    import seg_agu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    localparam int SEG_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pcop_e             pc_op,
    input  logic [ADDR_W-1:0] tgt,
    input  logic [SEG_W-1:0]  cs_seg,
    input  logic [SEG_W-1:0]  isr_seg,
    output logic [ADDR_W-1:0] pc_q,
    output logic [ADDR_W-1:0] link_q
);

    logic [ADDR_W-1:0] pc_d;
    logic              save_link;

    // Next program counter for each operation.
    always_comb begin
        unique case (pc_op)
            PC_REL:           pc_d = {pc_q[ADDR_W-1:OFF_W], pc_q[OFF_W-1:0] + tgt[OFF_W-1:0]};
            PC_LJMP, PC_LJSR: pc_d = {cs_seg, tgt[OFF_W-1:0]};
            PC_FAR, PC_FARL:  pc_d = tgt;
            PC_IRQ:           pc_d = {isr_seg, tgt[OFF_W-1:0]};
            default:          pc_d = pc_q;
        endcase
        save_link = (pc_op == PC_LJSR) || (pc_op == PC_FARL) || (pc_op == PC_IRQ);
    end

    // Register the program counter.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    // Capture the return address on calls and interrupt entry.
    always_ff @(posedge clk) begin
        if (!rst_n)         link_q <= '0;
        else if (save_link) link_q <= pc_q;
    end

    p_rel_keeps_seg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_op == PC_REL) |=> (pc_q[ADDR_W-1:OFF_W] == $past(pc_q[ADDR_W-1:OFF_W])));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pc_op == PC_HOLD) || (pc_op == PC_NOP7)) |=> $stable(pc_q));

    p_legacy_seg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((pc_op == PC_LJMP) || (pc_op == PC_LJSR)) |=> (pc_q[ADDR_W-1:OFF_W] == $past(cs_seg)));

    p_far_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((pc_op == PC_FAR) || (pc_op == PC_FARL)) |=> (pc_q == $past(tgt)));

    p_irq_seg_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_op == PC_IRQ) |=> (pc_q[ADDR_W-1:OFF_W] == $past(isr_seg)));

    p_link_saved_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((pc_op == PC_LJSR) || (pc_op == PC_FARL) || (pc_op == PC_IRQ)) |=> (link_q == $past(pc_q)));

    p_link_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !((pc_op == PC_LJSR) || (pc_op == PC_FARL) || (pc_op == PC_IRQ)) |=> $stable(link_q));

endmodule

// File: rtl/seg_agu.sv
// Top of the segmented address generation unit: segment register file,
// address former and program counter unit. Assumes decode drives the
// class, offsets and program counter commands each cycle.
module seg_agu
    import seg_agu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [2:0]        acc_class,
    input  logic [OFF_W-1:0]  offset,
    input  logic [OFF_W-1:0]  index,
    input  logic [2:0]        pc_op,
    input  logic [ADDR_W-1:0] tgt,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] link
);

    localparam int SEG_W = ADDR_W - OFF_W;
    localparam int ZPB_W = ADDR_W - PAGE_W;

    logic [NUM_SEG_REGS-1:0][ADDR_W-1:0] regs_q;
    logic                                unused_low_bits;

    // Only upper fields of most registers are significant.
    assign unused_low_bits = ^{regs_q[SEG_CS][OFF_W-1:0], regs_q[SEG_DS][OFF_W-1:0],
                               regs_q[SEG_US][OFF_W-1:0], regs_q[SEG_SYS1][OFF_W-1:0],
                               regs_q[SEG_ZP][PAGE_W-1:0]};

    seg_agu_regs #(
        .DATA_W (ADDR_W),
        .N_REGS (NUM_SEG_REGS),
        .SEL_W  (SEL_W)
    ) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .regs_q  (regs_q)
    );

    seg_agu_addr #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .PAGE_W (PAGE_W)
    ) i_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_class (acc_e'(acc_class)),
        .offset    (offset),
        .index     (index),
        .pc_seg    (pc[ADDR_W-1:OFF_W]),
        .ds_seg    (regs_q[SEG_DS][ADDR_W-1:OFF_W]),
        .us_seg    (regs_q[SEG_US][ADDR_W-1:OFF_W]),
        .zp_base   (regs_q[SEG_ZP][ADDR_W-1:PAGE_W]),
        .sys0      (regs_q[SEG_SYS0]),
        .bus_addr  (bus_addr)
    );

    seg_agu_pc #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W)
    ) i_pc (
        .clk     (clk),
        .rst_n   (rst_n),
        .pc_op   (pcop_e'(pc_op)),
        .tgt     (tgt),
        .cs_seg  (regs_q[SEG_CS][ADDR_W-1:OFF_W]),
        .isr_seg (regs_q[SEG_SYS1][ADDR_W-1:OFF_W]),
        .pc_q    (pc),
        .link_q  (link)
    );

    // Unused width guards: derived widths must stay positive.
    initial begin
        a_widths_ok: assert (SEG_W > 0 && ZPB_W > SEG_W);
    end

endmodule

// File: tb/test_seg_agu.sv
// Directed bench for seg_agu: one task per scenario, each checking itself.
module test_seg_agu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  acc_class = '0;
    logic [15:0] offset = '0;
    logic [15:0] index = '0;
    logic [2:0]  pc_op = '0;
    logic [31:0] tgt = '0;
    logic [31:0] bus_addr, pc, link;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    seg_agu i_seg_agu (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_sel (wr_sel),
        .wr_data (wr_data), .acc_class (acc_class), .offset (offset),
        .index (index), .pc_op (pc_op), .tgt (tgt),
        .bus_addr (bus_addr), .pc (pc), .link (link)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Write one segment register; it is visible after the next edge.
    task automatic wr(input logic [2:0] sel, input logic [31:0] d, input logic en);
        @(negedge clk);
        wr_en = en; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Form an address combinationally and compare.
    task automatic addr(input string req, input logic [2:0] c, input logic [15:0] o,
                        input logic [15:0] x, input logic [31:0] exp);
        @(negedge clk);
        acc_class = c; offset = o; index = x;
        #1;
        chk(req, bus_addr, exp);
    endtask

    // Apply one program counter operation for one edge.
    task automatic pcop(input logic [2:0] op, input logic [31:0] t);
        @(negedge clk);
        pc_op = op; tgt = t;
        @(negedge clk);
        pc_op = 3'd0;
    endtask

    task automatic t_reset;
        chk("R1 pc", pc, 32'h0);
        chk("R1 link", link, 32'h0);
        addr("R1 data seg zero", 3'd1, 16'h1234, 16'h0, 32'h0000_1234);
    endtask

    task automatic t_regs;
        wr(3'd0, 32'h0012_3456, 1'b1);
        wr(3'd1, 32'h0034_0000, 1'b1);
        wr(3'd2, 32'h0056_7800, 1'b1);
        wr(3'd3, 32'h0078_0000, 1'b1);
        wr(3'd4, 32'h009A_BC40, 1'b1);
        wr(3'd5, 32'h00DE_0000, 1'b1);
        addr("R2 data write", 3'd1, 16'h0010, 16'h0, 32'h0034_0010);
        wr(3'd6, 32'hFFFF_FFFF, 1'b1);
        wr(3'd7, 32'hFFFF_FFFF, 1'b1);
        wr(3'd1, 32'hFFFF_FFFF, 1'b0);
        addr("R2 ignored writes data", 3'd1, 16'h0010, 16'h0, 32'h0034_0010);
        addr("R2 ignored writes zp",   3'd2, 16'h0001, 16'h0, 32'h0056_7801);
        addr("R2 ignored writes sstk", 3'd3, 16'h0000, 16'h0, 32'h009A_BC40);
        addr("R2 ignored writes ustk", 3'd4, 16'h0000, 16'h0, 32'h0078_0000);
    endtask

    task automatic t_linear;
        addr("R3 data wrap", 3'd1, 16'hFFF0, 16'h0020, 32'h0034_0010);
        addr("R3 ustack",    3'd4, 16'h8000, 16'h0001, 32'h0078_8001);
        addr("R3 fetch",     3'd0, 16'h0100, 16'h0002, 32'h0000_0102);
        addr("R3 fetch wrap",3'd0, 16'hFFFF, 16'h0001, 32'h0000_0000);
    endtask

    task automatic t_zpage;
        addr("R4 zp page wrap", 3'd2, 16'h00F0, 16'h0020, 32'h0056_7810);
        addr("R4 zp high offset ignored", 3'd2, 16'h12AB, 16'h0000, 32'h0056_78AB);
    endtask

    task automatic t_sstack;
        addr("R5 sstack base", 3'd3, 16'h0000, 16'h0000, 32'h009A_BC40);
        addr("R5 sstack page wrap", 3'd3, 16'h00C5, 16'h0000, 32'h009A_BC05);
        addr("R5 sstack index ignored", 3'd3, 16'h00C5, 16'h0055, 32'h009A_BC05);
    endtask

    task automatic t_vector;
        addr("R6 vector seg zero", 3'd5, 16'hFFFA, 16'h0003, 32'h0000_FFFA);
        addr("R6 reserved class 6", 3'd6, 16'h1234, 16'h0001, 32'h0000_0000);
        addr("R6 reserved class 7", 3'd7, 16'h1234, 16'h0001, 32'h0000_0000);
    endtask

    task automatic t_pc_rel;
        pcop(3'd0, 32'hFFFF_FFFF);
        chk("R7 hold", pc, 32'h0);
        pcop(3'd4, 32'h1111_FFF0);
        chk("R9 far jump", pc, 32'h1111_FFF0);
        pcop(3'd1, 32'h0000_0020);
        chk("R7 relative wrap", pc, 32'h1111_0010);
        pcop(3'd1, 32'h0000_FFF0);
        chk("R7 relative backward", pc, 32'h1111_0000);
        pcop(3'd7, 32'h2222_3333);
        chk("R7 op 7 holds", pc, 32'h1111_0000);
        chk("R11 link kept", link, 32'h0);
    endtask

    task automatic t_legacy;
        pcop(3'd2, 32'hDEAD_4000);
        chk("R8 legacy jump", pc, 32'h0012_4000);
        // Call and code segment write in the same cycle.
        @(negedge clk);
        pc_op = 3'd3; tgt = 32'h0000_5000;
        wr_en = 1'b1; wr_sel = 3'd0; wr_data = 32'h0099_0000;
        @(negedge clk);
        pc_op = 3'd0; wr_en = 1'b0;
        chk("R8 call uses old cs", pc, 32'h0012_5000);
        chk("R11 link on legacy call", link, 32'h0012_4000);
        pcop(3'd2, 32'h0000_6000);
        chk("R8 legacy jump new cs", pc, 32'h0099_6000);
    endtask

    task automatic t_far_irq;
        pcop(3'd5, 32'hCAFE_0123);
        chk("R9 far call", pc, 32'hCAFE_0123);
        chk("R11 link on far call", link, 32'h0099_6000);
        pcop(3'd6, 32'h0000_8000);
        chk("R10 irq segment", pc, 32'h00DE_8000);
        chk("R11 link on irq", link, 32'hCAFE_0123);
        addr("R3 fetch in handler seg", 3'd0, 16'h0004, 16'h0, 32'h00DE_0004);
        pcop(3'd4, 32'h0000_0002);
        chk("R9 far jump", pc, 32'h0000_0002);
        chk("R11 link kept on far jump", link, 32'hCAFE_0123);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_regs;
        t_linear;
        t_zpage;
        t_sstack;
        t_vector;
        t_pc_rel;
        t_legacy;
        t_far_irq;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule